// File: doc/BRIEF.md
# Double-Buffered Split-Panel Frame Store

This block holds the pixel data for a 64×32 LED panel that is scanned two rows at a time. A producer writes one pixel per write-clock cycle into one frame buffer. At the same time, the panel scanner reads from the other frame buffer, which holds the complete previous frame. Storage is divided into two half arrays, one for the upper 16 rows and one for the lower 16 rows. A single read address therefore returns the upper pixel and the matching lower pixel together in the same cycle.

A single select input picks which buffer receives writes. The read side always uses the opposite buffer. When the producer has finished a frame, it flips the select. The frame it just wrote becomes visible to the scanner, and the next frame goes into the buffer that was on display until then. The write port and the read port are clocked independently. Each port has its own asynchronous active-low reset, which is released synchronously inside the block.

Top module: `fs_dual_half_store`

## Requirements
- R1: After the read reset is released and before any read is issued, `rd_top` and `rd_bot` are both zero.
- R2: A write with `wr_en` high and `wr_addr[10]` = 0 stores `wr_data` in the upper half array. The location is set by row `wr_addr[9:6]` (0..15) and column `wr_addr[5:0]`. It is later returned on `rd_top` for `rd_addr` = `wr_addr[9:0]`.
- R3: A write with `wr_addr[10]` = 1 (panel rows 16..31) stores into the lower half array. It is later returned on `rd_bot` for `rd_addr` = `wr_addr[9:0]`, which is panel row minus 16.
- R4: Writes go to the buffer numbered by `buf_sel`. Reads come from buffer `~buf_sel`. A frame written while `buf_sel` = s can be read back after `buf_sel` is changed to ~s.
- R5: Writes into the buffer being filled never change the data read back from the buffer on display.
- R6: A read issued at an `rd_clk` rising edge with `rd_en` high shows its data on `rd_top`/`rd_bot` right after that edge, which is one clock of latency. The outputs keep their previous value up to that edge.
- R7: While `rd_en` is low, `rd_top` and `rd_bot` hold their value, whatever `rd_addr` does.
- R8: While `wr_en` is low, changes on `wr_addr`/`wr_data` store nothing.
- R9: A single read returns both the upper-half and the lower-half pixel for the same row offset and column in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_addr | input | 11 | {row[4:0], column[5:0]}; bit 10 selects lower half |
| wr_data | input | 16 | Pixel to store |
| buf_sel | input | 1 | Buffer receiving writes; reads use the other one |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset |
| rd_en | input | 1 | Fetch a pixel pair this cycle |
| rd_addr | input | 10 | {row[3:0], column[5:0]} within a half |
| rd_top | output | 16 | Registered upper-half pixel |
| rd_bot | output | 16 | Registered lower-half pixel |

## Verification
Several internal faults look the same at the ports. If a write steers to the wrong half, or a buffer bit is inverted, or the read-side inversion is dropped, the scanner sees another frame's pixels, stale pixels, or the partner half's pixels. This shows in the first pair read after the select flips. The sweeps write every address of both frames with arithmetically distinct values, so any mix-up of half, row, column or buffer shows up as a value mismatch. A latency or enable fault shifts or overwrites the output register. That is visible one read-clock edge after the offending read, and the bench checks it there.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;

  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/fs_rst_sync.sv
module fs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fs_half_bank.sv
module fs_half_bank #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16
) (
  input  logic          wr_clk,
  input  logic          wr_srst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_srst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  // Write port: storage array, no reset.
  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read port: registered output with explicit enable.
  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge rd_clk or negedge rd_srst_n) begin
    if (!rd_srst_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R2: a write lands at its address
  p_write_lands_r2: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

  // R6: output carries the word addressed one edge earlier
  p_read_latency_r6: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    re |=> rdata == $past(mem[raddr]));

  // R7: idle read port holds its output
  p_hold_idle_r7: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    !re |=> $stable(rdata));

  // R1: output leaves reset at zero
  p_reset_clear_r1: assert property (@(posedge rd_clk) disable iff (!rd_srst_n)
    $rose(rd_srst_n) |-> rdata == '0);
endmodule

// File: rtl/fs_dual_half_store.sv
module fs_dual_half_store #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned ROW_W = 5,
  parameter int unsigned PIX_W = 16
) (
  input  logic                   wr_clk,
  input  logic                   wr_rst_n,
  input  logic                   wr_en,
  input  logic [ROW_W+COL_W-1:0] wr_addr,
  input  logic [PIX_W-1:0]       wr_data,
  input  logic                   buf_sel,
  input  logic                   rd_clk,
  input  logic                   rd_rst_n,
  input  logic                   rd_en,
  input  logic [ROW_W+COL_W-2:0] rd_addr,
  output logic [PIX_W-1:0]       rd_top,
  output logic [PIX_W-1:0]       rd_bot
);
  import fs_pkg::*;

  localparam int unsigned WA_W = ROW_W + COL_W;
  localparam int unsigned RA_W = WA_W - 1;
  localparam int unsigned LA_W = RA_W + 1;

  logic wr_srst_n;
  logic rd_srst_n;

  fs_rst_sync #(.STAGES(2)) i_wr_rst (
    .clk    (wr_clk),
    .arst_n (wr_rst_n),
    .srst_n (wr_srst_n)
  );

  fs_rst_sync #(.STAGES(2)) i_rd_rst (
    .clk    (rd_clk),
    .arst_n (rd_rst_n),
    .srst_n (rd_srst_n)
  );

  half_e                 wr_half;
  logic [LA_W-1:0]       wr_local;
  logic [LA_W-1:0]       rd_local;
  logic [NUM_HALVES-1:0] bank_we;
  logic [PIX_W-1:0]      bank_rdata [NUM_HALVES];

  always_comb begin
    wr_half  = half_e'(wr_addr[WA_W-1]);
    wr_local = {buf_sel, wr_addr[RA_W-1:0]};
    rd_local = {~buf_sel, rd_addr};
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign bank_we[h] = wr_en && wr_srst_n && (wr_half == half_e'(h));

    fs_half_bank #(.AW(LA_W), .DW(PIX_W)) i_bank (
      .wr_clk    (wr_clk),
      .wr_srst_n (wr_srst_n),
      .we        (bank_we[h]),
      .waddr     (wr_local),
      .wdata     (wr_data),
      .rd_clk    (rd_clk),
      .rd_srst_n (rd_srst_n),
      .re        (rd_en),
      .raddr     (rd_local),
      .rdata     (bank_rdata[h])
    );
  end

  assign rd_top = bank_rdata[HALF_UPPER];
  assign rd_bot = bank_rdata[HALF_LOWER];

  // R3: a write reaches exactly one half
  p_one_half_r3: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
    wr_en |-> $onehot(bank_we));

  // R8: no half is written while the write enable is low
  p_no_write_idle_r8: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
    !wr_en |-> bank_we == '0);

  // R4: write and read paths address opposite buffers
  p_opposite_buffers_r4: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
    wr_en |-> wr_local[LA_W-1] != rd_local[LA_W-1]);
endmodule

// File: tb/test_fs_dual_half_store.sv
module test_fs_dual_half_store;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        wr_rst_n;
  logic        rd_rst_n;
  logic        wr_en;
  logic [10:0] wr_addr;
  logic [15:0] wr_data;
  logic        buf_sel;
  logic        rd_en;
  logic [9:0]  rd_addr;
  logic [15:0] rd_top;
  logic [15:0] rd_bot;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  fs_dual_half_store i_fs_dual_half_store (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .buf_sel(buf_sel), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_top(rd_top), .rd_bot(rd_bot)
  );

  function automatic logic [15:0] pix(input int unsigned a, input int unsigned fr);
    return 16'((a * 40503 + fr * 23130 + 4660) & 16'hFFFF);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_px(input int unsigned a, input logic [15:0] d, input logic en);
    @(negedge wr_clk);
    wr_en = en; wr_addr = 11'(a); wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic write_frame(input int unsigned fr);
    for (int a = 0; a < 2048; a++) write_px(a, pix(a, fr), 1'b1);
  endtask

  task automatic read_pair(input int unsigned ra);
    @(negedge rd_clk);
    rd_en = 1'b1; rd_addr = 10'(ra);
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  // R2 R3 R9: every pair reads the upper and lower pixel of the same offset
  task automatic read_frame(input int unsigned fr, input string tag);
    for (int ra = 0; ra < 1024; ra++) begin
      read_pair(ra);
      check({tag, " R2 upper"}, rd_top, pix(ra, fr));
      check({tag, " R3/R9 lower"}, rd_bot, pix(ra + 1024, fr));
    end
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; buf_sel = 1'b0;
    rd_en = 1'b0; rd_addr = '0;
    #40ns;
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);

    // R1: outputs zero out of reset
    check("R1 top", rd_top, 16'h0000);
    check("R1 bot", rd_bot, 16'h0000);

    // Frame 0 into buffer 0
    write_frame(0);
    // R8: disabled writes aimed at buffer 0 with junk
    for (int a = 0; a < 2048; a += 37) write_px(a, ~pix(a, 0), 1'b0);

    // R4: flip, frame 0 becomes visible; R8 confirmed by intact data
    buf_sel = 1'b1;
    read_frame(0, "R4/R8 frame0");

    // R5: fill buffer 1 while buffer 0 is on display, then recheck buffer 0
    for (int a = 0; a < 2048; a++) begin
      write_px(a, pix(a, 1), 1'b1);
      if (a % 256 == 0) begin
        read_pair(a % 1024);
        check("R5 mid-fill upper", rd_top, pix(a % 1024, 0));
        check("R5 mid-fill lower", rd_bot, pix((a % 1024) + 1024, 0));
      end
    end
    read_frame(0, "R5 after fill");

    // R4: flip back, frame 1 visible
    buf_sel = 1'b0;
    read_frame(1, "R4 frame1");

    // R6: value changes only at the read edge
    read_pair(5);
    @(negedge rd_clk);
    rd_en = 1'b1; rd_addr = 10'd900;
    check("R6 before edge", rd_top, pix(5, 1));
    @(negedge rd_clk);
    rd_en = 1'b0;
    check("R6 after edge top", rd_top, pix(900, 1));
    check("R6 after edge bot", rd_bot, pix(1924, 1));

    // R7: address moves with enable low, outputs hold
    for (int k = 0; k < 6; k++) begin
      @(negedge rd_clk);
      rd_addr = 10'(k * 111);
      @(negedge rd_clk);
      check("R7 hold top", rd_top, pix(900, 1));
      check("R7 hold bot", rd_bot, pix(1924, 1));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule